// File: doc/BRIEF.md
# Two-Stage Pipelined Core with Branch Flush

This block is a small in-order processor core built from two stages joined by a one-entry holding slot. The front stage reads one instruction word per cycle from an external instruction memory, reads the register operands that the word names, and places the decoded operation together with those operand values into the slot. The back stage takes the slot's content in the following cycle and carries it out. It can write the register file, write or read an internal data memory, or redirect the program counter.

Within a cycle the back stage is ordered before the front stage. A register written by the back stage is therefore seen by the operand read of the instruction fetched in the same cycle, and the slot drains and refills in one cycle. The core sustains one instruction per cycle. The one exception is a taken branch-if-zero. It sets the program counter to its target, empties the slot and throws away the word fetched in that cycle, which costs one idle cycle. A hazard check holds fetch when an operand depends on a buffered result that is not yet available. With forwarding enabled, which is the default, that case never arises.

The register writes, data-memory writes, redirects and the fetch address are brought out as ports, so that an environment can trace the core's progress.

Top module: `twostage_core`

## Requirements
- R1: After reset the fetch address is 0 and the slot is empty. In the first cycle after reset, rf_we, dm_we and redirect are all low.
- R2: In every cycle without a redirect or stall, the fetched word enters the slot and the fetch address advances by one, wrapping at 2^PC_W.
- R3: An instruction word is {op[23:20], rd[19:16], rs1[15:12], rs2[11:8], imm[7:0]}. The op codes are 1 add, 2 branch-if-zero, 3 load, 4 store and 5 load-immediate. In any cycle at most one of rf_we, dm_we and redirect is high.
- R4: An add writes (r[rs1] + r[rs2]) mod 2^16 to rd, in the cycle after it was fetched.
- R5: A load-immediate writes the zero-extended imm to rd.
- R6: A load writes dmem[r[rs1] mod 16] to rd. A store raises dm_we with address r[rs1] mod 16 and data r[rs2], and later loads return that data.
- R7: A branch-if-zero with r[rs1] == 0 raises redirect. The next fetch address is imm, and the word fetched in the redirect cycle has no effect.
- R8: A branch-if-zero with r[rs1] != 0 raises no redirect and does nothing else, and fetch continues at the next address.
- R9: A register written in a cycle is the operand value of the instruction fetched in that same cycle. With forwarding enabled, fetch_stall stays low.
- R10: Op codes 0 and 6 to 15 write nothing and do not redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Fetch address (program counter) |
| imem_data | input | 24 | Instruction word at imem_addr, same cycle |
| rf_we | output | 1 | Register write this cycle |
| rf_waddr | output | 4 | Register written |
| rf_wdata | output | 16 | Value written |
| dm_we | output | 1 | Data-memory write this cycle |
| dm_addr | output | 4 | Data-memory address written |
| dm_wdata | output | 16 | Data-memory value written |
| redirect | output | 1 | Taken branch this cycle |
| fetch_stall | output | 1 | Fetch held by the hazard check |

## Verification
The hardest situation to reach is a taken branch whose discarded companion word would visibly change state. The branch must find its register at zero, and the next word must be a register or memory write whose trace would expose a missing flush. The directed program places a load-immediate directly behind a branch on a zeroed register for this purpose. Back-to-back dependent adds, a store followed by a load and a load followed by a use exercise forwarding. Randomly generated programs then drive branches into arbitrary targets, including self-loops, while a behavioural model predicts every port on every cycle.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_NOP = 4'd0;
  localparam logic [OPW-1:0] OP_ADD = 4'd1;
  localparam logic [OPW-1:0] OP_BZ  = 4'd2;
  localparam logic [OPW-1:0] OP_LD  = 4'd3;
  localparam logic [OPW-1:0] OP_ST  = 4'd4;
  localparam logic [OPW-1:0] OP_LI  = 4'd5;

  // instruction produces a register result
  function automatic logic op_writes_rd(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_LD) || (op == OP_LI);
  endfunction

  function automatic logic op_reads_rs1(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_BZ) || (op == OP_LD) || (op == OP_ST);
  endfunction

  function automatic logic op_reads_rs2(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_ST);
  endfunction
endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 16,
  parameter int NRD  = 2,
  parameter bit FWD  = 1'b1,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [NRD*AW-1:0]   raddr,
  output logic [NRD*XLEN-1:0] rdata
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = raddr[g*AW +: AW];
    if (FWD) begin : g_fwd
      // write ordered before read within a cycle
      assign rdata[g*XLEN +: XLEN] = (we && (waddr == ra)) ? wdata : regs_q[ra];
    end else begin : g_plain
      assign rdata[g*XLEN +: XLEN] = regs_q[ra];
    end
  end

  // R9
  reg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/core_exec.sv
module core_exec
  import core_pkg::*;
#(
  parameter int XLEN     = 16,
  parameter int RIDX_W   = 4,
  parameter int PC_W     = 8,
  parameter int DM_DEPTH = 16,
  localparam int DM_AW   = $clog2(DM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [OPW-1:0]    op,
  input  logic [RIDX_W-1:0] rd,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [PC_W-1:0]   imm,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [XLEN-1:0]   dm_wdata,
  output logic              taken,
  output logic [PC_W-1:0]   target,
  output logic              deq
);
  logic [XLEN-1:0] dmem_q [DM_DEPTH];
  logic [XLEN-1:0] ld_data;

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [PC_W-1:0] v);
    logic [XLEN-1:0] r;
    r = '0;
    r[PC_W-1:0] = v;
    return r;
  endfunction

  assign dm_addr  = a[DM_AW-1:0];
  assign dm_wdata = b;
  assign ld_data  = dmem_q[dm_addr];
  assign target   = imm;
  assign rf_waddr = rd;

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = '0;
    dm_we    = 1'b0;
    taken    = 1'b0;
    if (valid) begin
      unique case (op)
        OP_ADD: begin rf_we = 1'b1; rf_wdata = wrap_add(a, b); end
        OP_LI:  begin rf_we = 1'b1; rf_wdata = zext_imm(imm); end
        OP_LD:  begin rf_we = 1'b1; rf_wdata = ld_data; end
        OP_ST:  dm_we = 1'b1;
        OP_BZ:  taken = (a == '0);
        default: ;
      endcase
    end
  end

  // every executed instruction except a taken branch leaves the slot
  assign deq = valid && !taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DM_DEPTH; i++) dmem_q[i] <= '0;
    end else if (dm_we) begin
      dmem_q[dm_addr] <= dm_wdata;
    end
  end

  // R6
  st_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> dmem_q[$past(dm_addr)] == $past(dm_wdata));
endmodule

// File: rtl/core_fetch.sv
module core_fetch
  import core_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int RIDX_W = 4,
  parameter int PC_W   = 8,
  parameter bit FWD    = 1'b1,
  localparam int ILEN  = OPW + 3*RIDX_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ILEN-1:0]   instr,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic              deq,
  input  logic              flush,
  input  logic [PC_W-1:0]   flush_pc,
  output logic [PC_W-1:0]   pc,
  output logic [RIDX_W-1:0] rs1_idx,
  output logic [RIDX_W-1:0] rs2_idx,
  output logic              stall,
  output logic              buf_valid,
  output logic [OPW-1:0]    buf_op,
  output logic [RIDX_W-1:0] buf_rd,
  output logic [XLEN-1:0]   buf_a,
  output logic [XLEN-1:0]   buf_b,
  output logic [PC_W-1:0]   buf_imm
);
  logic [OPW-1:0]    f_op;
  logic [RIDX_W-1:0] f_rd;
  logic [PC_W-1:0]   f_imm;
  logic              pending_wr;
  logic              hit1, hit2;
  logic              fire;
  logic [PC_W-1:0]   pc_q;

  assign {f_op, f_rd, rs1_idx, rs2_idx, f_imm} = instr;

  // a buffered result-producing entry is a hazard unless it retires now with forwarding
  assign pending_wr = buf_valid && op_writes_rd(buf_op) && !(FWD && deq);
  assign hit1  = op_reads_rs1(f_op) && (rs1_idx == buf_rd);
  assign hit2  = op_reads_rs2(f_op) && (rs2_idx == buf_rd);
  assign stall = pending_wr && (hit1 || hit2);

  assign fire = !flush && !stall && (!buf_valid || deq);
  assign pc   = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      buf_valid <= 1'b0;
      buf_op    <= OP_NOP;
      buf_rd    <= '0;
      buf_a     <= '0;
      buf_b     <= '0;
      buf_imm   <= '0;
    end else if (flush) begin
      pc_q      <= flush_pc;
      buf_valid <= 1'b0;
    end else if (fire) begin
      pc_q      <= pc_q + 1'b1;
      buf_valid <= 1'b1;
      buf_op    <= f_op;
      buf_rd    <= f_rd;
      buf_a     <= rs1_val;
      buf_b     <= rs2_val;
      buf_imm   <= f_imm;
    end else if (deq) begin
      buf_valid <= 1'b0;
    end
  end

  // R7
  redir_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pc == $past(flush_pc));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !buf_valid);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall) |=> pc == $past(pc) + 1'b1);
  // R2
  fetch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall) |=> buf_valid);
endmodule

// File: rtl/twostage_core.sv
module twostage_core
  import core_pkg::*;
#(
  parameter int XLEN     = 16,
  parameter int NREG     = 16,
  parameter int PC_W     = 8,
  parameter int DM_DEPTH = 16,
  parameter bit FWD      = 1'b1,
  localparam int RIDX_W  = $clog2(NREG),
  localparam int DM_AW   = $clog2(DM_DEPTH),
  localparam int ILEN    = OPW + 3*RIDX_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [ILEN-1:0]   imem_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [XLEN-1:0]   dm_wdata,
  output logic              redirect,
  output logic              fetch_stall
);
  logic [RIDX_W-1:0] rs1_idx, rs2_idx;
  logic [XLEN-1:0]   rs1_val, rs2_val;
  logic              deq;
  logic [PC_W-1:0]   br_target;
  logic              buf_valid;
  logic [OPW-1:0]    buf_op;
  logic [RIDX_W-1:0] buf_rd;
  logic [XLEN-1:0]   buf_a, buf_b;
  logic [PC_W-1:0]   buf_imm;

  core_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2), .FWD(FWD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr ({rs2_idx, rs1_idx}),
    .rdata ({rs2_val, rs1_val})
  );

  core_fetch #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_W(PC_W), .FWD(FWD)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (imem_data),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .deq       (deq),
    .flush     (redirect),
    .flush_pc  (br_target),
    .pc        (imem_addr),
    .rs1_idx   (rs1_idx),
    .rs2_idx   (rs2_idx),
    .stall     (fetch_stall),
    .buf_valid (buf_valid),
    .buf_op    (buf_op),
    .buf_rd    (buf_rd),
    .buf_a     (buf_a),
    .buf_b     (buf_b),
    .buf_imm   (buf_imm)
  );

  core_exec #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_W(PC_W), .DM_DEPTH(DM_DEPTH)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (buf_valid),
    .op       (buf_op),
    .rd       (buf_rd),
    .a        (buf_a),
    .b        (buf_b),
    .imm      (buf_imm),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .dm_we    (dm_we),
    .dm_addr  (dm_addr),
    .dm_wdata (dm_wdata),
    .taken    (redirect),
    .target   (br_target),
    .deq      (deq)
  );

  // R3
  exec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, dm_we, redirect}));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !rf_we && !dm_we && !redirect && (imem_addr == '0));
endmodule

// File: tb/twostage_core_bench.sv
module twostage_core_bench;
  localparam int XLEN = 16;
  localparam int PC_W = 8;
  localparam int ILEN = 24;
  localparam int IMEM = 1 << PC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic [ILEN-1:0] imem_data;
  logic rf_we, dm_we, redirect, fetch_stall;
  logic [3:0] rf_waddr, dm_addr;
  logic [XLEN-1:0] rf_wdata, dm_wdata;

  logic [ILEN-1:0] imem [IMEM];
  assign imem_data = imem[imem_addr];

  always #2 clk = ~clk;

  twostage_core u_twostage_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .redirect(redirect), .fetch_stall(fetch_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [XLEN-1:0] m_rf [16];
  logic [XLEN-1:0] m_dm [16];
  logic [PC_W-1:0] m_pc;
  // pending slot: {op, rd, a, b, imm}
  logic [47:0] pend [$];

  function automatic logic [ILEN-1:0] enc(input int op, input int rd, input int s1, input int s2, input int imm);
    return {op[3:0], rd[3:0], s1[3:0], s2[3:0], imm[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_rf[i] = '0; m_dm[i] = '0; end
    m_pc = '0;
    pend.delete();
  endtask

  // called at a negedge: compare ports, then advance the model past the next posedge
  task automatic step();
    bit e_rfwe, e_dmwe, e_tk;
    logic [3:0] e_wa, e_da, op, rd;
    logic [XLEN-1:0] e_wd, e_dd, a, b;
    logic [7:0] imm;
    string tag;
    logic [ILEN-1:0] w;
    e_rfwe = 0; e_dmwe = 0; e_tk = 0; e_wa = 0; e_da = 0; e_wd = 0; e_dd = 0;
    tag = "R10";
    if (pend.size() != 0) begin
      {op, rd, a, b, imm} = pend[0];
      case (op)
        4'd1: begin tag = "R4/R9"; e_rfwe = 1; e_wa = rd; e_wd = a + b; end
        4'd5: begin tag = "R5"; e_rfwe = 1; e_wa = rd; e_wd = {8'h00, imm}; end
        4'd3: begin tag = "R6"; e_rfwe = 1; e_wa = rd; e_wd = m_dm[a[3:0]]; end
        4'd4: begin tag = "R6"; e_dmwe = 1; e_da = a[3:0]; e_dd = b; end
        4'd2: begin e_tk = (a == 0); tag = e_tk ? "R7" : "R8"; end
        default: tag = "R10";
      endcase
    end else tag = "R7/R1";
    chk(imem_addr == m_pc, "R2", "fetch address", imem_addr, m_pc);
    chk(redirect == e_tk, tag, "redirect", redirect, e_tk);
    chk(rf_we == e_rfwe, tag, "rf_we", rf_we, e_rfwe);
    if (e_rfwe && rf_we)
      chk(rf_waddr == e_wa && rf_wdata == e_wd, tag, "rf write",
          {rf_waddr, rf_wdata}, {e_wa, e_wd});
    chk(dm_we == e_dmwe, tag, "dm_we", dm_we, e_dmwe);
    if (e_dmwe && dm_we)
      chk(dm_addr == e_da && dm_wdata == e_dd, tag, "dm write",
          {dm_addr, dm_wdata}, {e_da, e_dd});
    chk(fetch_stall == 1'b0, "R9", "fetch_stall", fetch_stall, 0);
    // advance: execute first, then fetch
    if (e_rfwe) m_rf[e_wa] = e_wd;
    if (e_dmwe) m_dm[e_da] = e_dd;
    if (pend.size() != 0) void'(pend.pop_front());
    if (e_tk) begin
      m_pc = imm;
    end else begin
      w = imem[m_pc];
      pend.push_back({w[23:20], w[19:16], m_rf[w[15:12]], m_rf[w[11:8]], w[7:0]});
      m_pc = m_pc + 1'b1;
    end
  endtask

  task automatic run(input int cycles);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R1: first cycle out of reset
    chk(imem_addr == 0 && !rf_we && !dm_we && !redirect, "R1", "reset state",
        {imem_addr, rf_we, dm_we, redirect}, 0);
    for (int c = 0; c < cycles; c++) begin
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    // directed program; field layout per R3
    for (int i = 0; i < IMEM; i++) imem[i] = enc(2, 0, 0, 0, 17);
    imem[0]  = enc(5, 1, 0, 0, 5);      // LI r1,5         R5
    imem[1]  = enc(5, 2, 0, 0, 7);      // LI r2,7
    imem[2]  = enc(1, 3, 1, 2, 0);      // ADD r3 = 12     R4 R9
    imem[3]  = enc(1, 4, 3, 3, 0);      // ADD r4 = 24     R9
    imem[4]  = enc(4, 0, 1, 4, 0);      // ST [5] = 24     R6
    imem[5]  = enc(3, 5, 1, 0, 0);      // LD r5 = 24      R6
    imem[6]  = enc(1, 6, 5, 1, 0);      // ADD r6 = 29     R9
    imem[7]  = enc(2, 0, 1, 0, 40);     // BZ r1 not taken R8
    imem[8]  = enc(2, 0, 0, 0, 12);     // BZ r0 taken     R7
    imem[9]  = enc(5, 7, 0, 0, 99);     // discarded       R7
    imem[10] = enc(4, 0, 0, 1, 0);      // never reached
    imem[12] = enc(5, 7, 0, 0, 3);      // LI r7,3
    imem[13] = enc(4, 0, 7, 6, 0);      // ST [3] = 29
    imem[14] = enc(9, 1, 1, 1, 8'hff);  // unused op       R10
    imem[15] = enc(0, 2, 2, 2, 1);      // NOP             R10
    imem[16] = enc(5, 9, 0, 0, 255);    // LI r9,255
    imem[17] = enc(2, 0, 0, 0, 17);     // self-loop
    run(40);
    // random programs
    void'($urandom(32'h5eed_0042));
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < IMEM; i++) begin
        int op;
        op = $urandom_range(0, 9);
        if (op > 6) op = $urandom_range(1, 5);
        imem[i] = enc(op, $urandom_range(0, 15), $urandom_range(0, 15),
                      $urandom_range(0, 15), $urandom_range(0, 255));
      end
      run(600);
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule